// File: doc/BRIEF.md
# Zero-Turnaround Pipelined Burst SRAM

This block is a synthesizable synchronous static memory, 18 bits wide in two 9-bit byte lanes, with no idle cycle needed when the bus changes direction. Every enabled rising clock edge accepts one command. The command is formed from three chip selects, a load/continue select, a direction select, per-lane write enables and an output enable. A read returns its data two enabled edges after the address edge. A write takes its data on that same later edge, so reads and writes can follow each other on consecutive cycles.

A command that loads an address starts a burst. Continue cycles then step a 2-bit counter through either an interleaved or a linear sequence of the two low address bits. The sequence is chosen when the burst starts. Continue cycles repeat the direction fixed at the burst start. Deselect, dummy-read and write-abort cycles move through the pipeline without touching memory or the bus. A clock-enable input held high freezes the whole block for that edge.

The bidirectional data pins are split into a data input, a data output and an output-drive flag.

Top module: `zt_sram`

## Requirements
- R1: With `burst_ilv`=1 when the burst starts, a burst from low address bits s visits s, s^1, s^2, s^3. The upper address bits stay fixed.
- R2: With `burst_ilv`=0 when the burst starts, a burst from low address bits s visits s, s+1, s+2, s+3, taken modulo 4.
- R3: The burst counter is 2 bits wide. The fourth continue cycle after a burst start targets the start address again.
- R4: A cycle with `adv_ld`=1 continues the burst. It repeats the direction chosen at the burst start whatever `we_n` is. A read burst started with `oe_n`=1 stays a dummy burst.
- R5: A cycle with `adv_ld`=0 and any chip select inactive is a deselect: it writes nothing and leaves `dout_en`=0. Continue cycles that follow a deselect are also deselects, even with the chips selected and `we_n`=0.
- R6: A write with `bw_n`=2'b11 is a write abort and changes no word. A continue cycle of that burst with `bw_n`=2'b11 also writes nothing.
- R7: `bw_n[0]`=0 writes data bits [8:0] and `bw_n[1]`=0 writes bits [17:9]. A lane whose enable is 1 keeps its old contents.
- R8: An edge with `cke_n`=1 is ignored. No memory word changes, and `dout` and `dout_en` keep their values.
- R9: `dout_en` is 0 after every edge that executes a write data cycle, even with `oe_n`=0.
- R10: A read started with `oe_n`=1 is a dummy read. It and its continue cycles leave `dout_en`=0.
- R11: Read data is on `dout`, with `dout_en`=1, right after the second enabled edge following its address edge. Write data on `din` is taken at that second enabled edge. Reads and writes can alternate on every cycle.
- R12: While `rst_n`=0 and after reset, `dout_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| cke_n | input | 1 | Clock enable, active low; high makes a wait state |
| cs0_n | input | 1 | Chip select, active low |
| cs1 | input | 1 | Chip select, active high |
| cs2_n | input | 1 | Chip select, active low |
| adv_ld | input | 1 | 0 loads an address and starts a burst, 1 continues it |
| we_n | input | 1 | Direction at burst start: 0 write, 1 read |
| bw_n | input | 2 | Per-lane write enables, active low |
| oe_n | input | 1 | Output enable, active low, taken at read burst start |
| burst_ilv | input | 1 | Burst order at burst start: 1 interleaved, 0 linear |
| addr | input | ADDR_W | Word address |
| din | input | 18 | Write data |
| dout | output | 18 | Read data |
| dout_en | output | 1 | Output drive; 0 means the bus is high impedance |

## Verification
A burst counter or an order latch in the wrong state does not show up at once. Data lands at the wrong word, and this becomes visible only when a later read of that word returns the wrong value. The bench therefore reads back every address a burst touches. A stage register or a latched direction in the wrong state shows two enabled edges after the command, as a wrong `dout_en` or wrong data. A write in the wrong state corrupts a word that is exposed on the next read of it.

// File: rtl/zt_pkg.sv
package zt_pkg;
    localparam int LANE_W = 9;
    localparam int LANES  = 2;
    localparam int CNT_W  = 2;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } op_e;
endpackage

// File: rtl/zt_cmd_decode.sv
module zt_cmd_decode
    import zt_pkg::*;
#(
    parameter int LANES = zt_pkg::LANES
) (
    input  logic             sel,
    input  logic             adv_ld,
    input  logic             we_n,
    input  logic [LANES-1:0] bw_n,
    input  logic             oe_n,
    input  op_e              brst_op_q,
    input  logic             brst_dummy_q,
    output logic             begin_burst,
    output op_e              cyc_op,
    output logic             cyc_dummy,
    output logic [LANES-1:0] cyc_be,
    output op_e              brst_op_d,
    output logic             brst_dummy_d
);
    always_comb begin
        begin_burst  = !adv_ld;
        cyc_op       = OP_IDLE;
        cyc_dummy    = 1'b0;
        if (!adv_ld) begin
            if (!sel) begin
                cyc_op = OP_IDLE;
            end else if (!we_n) begin
                cyc_op = OP_WRITE;
            end else begin
                cyc_op    = OP_READ;
                cyc_dummy = oe_n;
            end
            brst_op_d    = cyc_op;
            brst_dummy_d = cyc_dummy;
        end else begin
            // continuation keeps the burst's own direction
            cyc_op       = brst_op_q;
            cyc_dummy    = brst_dummy_q;
            brst_op_d    = brst_op_q;
            brst_dummy_d = brst_dummy_q;
        end
        cyc_be = (cyc_op == OP_WRITE) ? ~bw_n : '0;
    end
endmodule

// File: rtl/zt_burst_seq.sv
module zt_burst_seq #(
    parameter int ADDR_W = 5,
    parameter int CNT_W  = 2
) (
    input  logic              load,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic [ADDR_W-1:0] base_q,
    input  logic [CNT_W-1:0]  cnt_q,
    input  logic              ilv_q,
    output logic [ADDR_W-1:0] cyc_addr,
    output logic [CNT_W-1:0]  cnt_d
);
    logic [CNT_W-1:0] low;

    always_comb begin
        if (load) begin
            cnt_d    = '0;
            low      = ld_addr[CNT_W-1:0];
            cyc_addr = ld_addr;
        end else begin
            cnt_d    = cnt_q + 1'b1;
            low      = ilv_q ? (base_q[CNT_W-1:0] ^ cnt_d)
                             : (base_q[CNT_W-1:0] + cnt_d);
            cyc_addr = {base_q[ADDR_W-1:CNT_W], low};
        end
    end
endmodule

// File: rtl/zt_lane_array.sv
module zt_lane_array #(
    parameter int ADDR_W = 5,
    parameter int LANE_W = 9,
    parameter int LANES  = 2
) (
    input  logic                     clk,
    input  logic [LANES-1:0]         lane_we,
    input  logic [ADDR_W-1:0]        addr,
    input  logic [LANE_W*LANES-1:0]  wdata,
    output logic [LANE_W*LANES-1:0]  rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] store [DEPTH];

        always_ff @(posedge clk) begin
            if (lane_we[g]) begin
                store[addr] <= wdata[g*LANE_W +: LANE_W];
            end
        end

        assign rdata[g*LANE_W +: LANE_W] = store[addr];
    end
endmodule

// File: rtl/zt_sram.sv
module zt_sram
    import zt_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int LANE_W = zt_pkg::LANE_W,
    parameter int LANES  = zt_pkg::LANES
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cke_n,
    input  logic                    cs0_n,
    input  logic                    cs1,
    input  logic                    cs2_n,
    input  logic                    adv_ld,
    input  logic                    we_n,
    input  logic [LANES-1:0]        bw_n,
    input  logic                    oe_n,
    input  logic                    burst_ilv,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [LANE_W*LANES-1:0] din,
    output logic [LANE_W*LANES-1:0] dout,
    output logic                    dout_en
);
    localparam int DATA_W = LANE_W * LANES;

    typedef struct packed {
        op_e               b_op;
        logic              b_dummy;
        logic              b_ilv;
        logic [ADDR_W-1:0] b_base;
        logic [CNT_W-1:0]  b_cnt;
        op_e               s1_op;
        logic              s1_dummy;
        logic [ADDR_W-1:0] s1_addr;
        logic [LANES-1:0]  s1_be;
        op_e               s2_op;
        logic              s2_dummy;
        logic [ADDR_W-1:0] s2_addr;
        logic [LANES-1:0]  s2_be;
        logic [DATA_W-1:0] rd;
        logic              drv;
    } st_t;

    st_t state_d, state_q;

    logic              sel;
    logic              begin_burst;
    op_e               cyc_op, dec_bop;
    logic              cyc_dummy, dec_bdum;
    logic [LANES-1:0]  cyc_be;
    logic [ADDR_W-1:0] seq_addr;
    logic [CNT_W-1:0]  seq_cnt;
    logic [LANES-1:0]  lane_we;
    logic [DATA_W-1:0] arr_rdata;
    logic              exec_wr, exec_rd, exec_dummy;

    assign sel        = !cs0_n && cs1 && !cs2_n;
    assign exec_wr    = (state_q.s2_op == OP_WRITE);
    assign exec_rd    = (state_q.s2_op == OP_READ);
    assign exec_dummy = state_q.s2_dummy;
    assign lane_we    = (!cke_n && exec_wr) ? state_q.s2_be : '0;

    zt_cmd_decode #(.LANES(LANES)) i_dec (
        .sel          (sel),
        .adv_ld       (adv_ld),
        .we_n         (we_n),
        .bw_n         (bw_n),
        .oe_n         (oe_n),
        .brst_op_q    (state_q.b_op),
        .brst_dummy_q (state_q.b_dummy),
        .begin_burst  (begin_burst),
        .cyc_op       (cyc_op),
        .cyc_dummy    (cyc_dummy),
        .cyc_be       (cyc_be),
        .brst_op_d    (dec_bop),
        .brst_dummy_d (dec_bdum)
    );

    zt_burst_seq #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) i_seq (
        .load     (begin_burst),
        .ld_addr  (addr),
        .base_q   (state_q.b_base),
        .cnt_q    (state_q.b_cnt),
        .ilv_q    (state_q.b_ilv),
        .cyc_addr (seq_addr),
        .cnt_d    (seq_cnt)
    );

    zt_lane_array #(.ADDR_W(ADDR_W), .LANE_W(LANE_W), .LANES(LANES)) i_arr (
        .clk     (clk),
        .lane_we (lane_we),
        .addr    (state_q.s2_addr),
        .wdata   (din),
        .rdata   (arr_rdata)
    );

    always_comb begin
        state_d = state_q;
        if (!cke_n) begin
            state_d.b_op    = dec_bop;
            state_d.b_dummy = dec_bdum;
            state_d.b_cnt   = seq_cnt;
            if (begin_burst) begin
                state_d.b_base = addr;
                state_d.b_ilv  = burst_ilv;
            end
            state_d.s1_op    = cyc_op;
            state_d.s1_dummy = cyc_dummy;
            state_d.s1_addr  = seq_addr;
            state_d.s1_be    = cyc_be;
            state_d.s2_op    = state_q.s1_op;
            state_d.s2_dummy = state_q.s1_dummy;
            state_d.s2_addr  = state_q.s1_addr;
            state_d.s2_be    = state_q.s1_be;
            if (exec_rd) begin
                state_d.rd  = arr_rdata;
                state_d.drv = !state_q.s2_dummy;
            end else begin
                state_d.drv = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign dout    = state_q.rd;
    assign dout_en = state_q.drv;
endmodule

// File: rtl/zt_sram_chk.sv
module zt_sram_chk #(
    parameter int DATA_W = 18
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cke_n,
    input logic              cs0_n,
    input logic              cs1,
    input logic              cs2_n,
    input logic              adv_ld,
    input logic [DATA_W-1:0] dout,
    input logic              dout_en,
    input logic              exec_wr,
    input logic              exec_rd,
    input logic              exec_dummy
);
    logic chip_on;
    assign chip_on = !cs0_n && cs1 && !cs2_n;

    // R12
    reset_quiet_chk: assert property (@(posedge clk) !rst_n |=> !dout_en);

    // R8
    wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cke_n |=> ($stable(dout) && $stable(dout_en)));

    // R9
    write_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_wr && !cke_n) |=> !dout_en);

    // R10
    dummy_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_rd && exec_dummy && !cke_n) |=> !dout_en);

    // R11
    read_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_rd && !exec_dummy && !cke_n) |=> dout_en);

    // R5
    deselect_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke_n && !adv_ld && !chip_on) ##1 !cke_n ##1 !cke_n |=> !dout_en);
endmodule

bind zt_sram zt_sram_chk #(.DATA_W(LANE_W * LANES)) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cke_n      (cke_n),
    .cs0_n      (cs0_n),
    .cs1        (cs1),
    .cs2_n      (cs2_n),
    .adv_ld     (adv_ld),
    .dout       (dout),
    .dout_en    (dout_en),
    .exec_wr    (exec_wr),
    .exec_rd    (exec_rd),
    .exec_dummy (exec_dummy)
);

// File: tb/test_zt_sram.sv
module test_zt_sram;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 5;
    localparam int LW = 9;
    localparam int NL = 2;
    localparam int DW = LW * NL;
    localparam int E_IDLE = 0, E_RD = 1, E_WR = 2;

    logic clk = 1'b0, rst_n = 1'b0, cke_n = 1'b1;
    logic cs0_n = 1'b1, cs1 = 1'b0, cs2_n = 1'b1;
    logic adv_ld = 1'b0, we_n = 1'b1, oe_n = 1'b1, burst_ilv = 1'b0;
    logic [NL-1:0] bw_n = '1;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] din = '0;
    logic [DW-1:0] dout;
    logic          dout_en;

    int n_chk = 0, n_err = 0;
    string tag = "R12";
    bit done = 0;

    logic [DW-1:0] m_mem [1 << AW];
    int            q_op   [2];
    int            q_addr [2];
    logic [NL-1:0] q_be   [2];
    bit            q_dum  [2];
    logic [DW-1:0] q_dat  [2];
    logic [DW-1:0] e_dout = '0;
    bit            e_en = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    zt_sram #(.ADDR_W(AW)) i_zt_sram (
        .clk(clk), .rst_n(rst_n), .cke_n(cke_n), .cs0_n(cs0_n), .cs1(cs1),
        .cs2_n(cs2_n), .adv_ld(adv_ld), .we_n(we_n), .bw_n(bw_n), .oe_n(oe_n),
        .burst_ilv(burst_ilv), .addr(addr), .din(din), .dout(dout), .dout_en(dout_en)
    );

    task automatic check(string req, bit ok, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] fdat(int k);
        return DW'((k * 2731 + 17) ^ (k << 9));
    endfunction

    function automatic int blow(bit ilv, int s, int i);
        return ilv ? ((s ^ i) & 3) : ((s + i) & 3);
    endfunction

    task automatic cyc(bit sel, bit adv, bit wn, logic [NL-1:0] bwn, bit oen, int a, bit hold,
                       int eop, int ea, logic [NL-1:0] ebe, bit edum, logic [DW-1:0] edat);
        cs0_n = !sel; cs1 = sel; cs2_n = !sel;
        adv_ld = adv; we_n = wn; bw_n = bwn; oe_n = oen;
        addr = a[AW-1:0]; cke_n = hold; din = q_dat[1];
        @(posedge clk);
        if (!hold) begin
            if (q_op[1] == E_WR)
                for (int l = 0; l < NL; l++)
                    if (q_be[1][l]) m_mem[q_addr[1]][l*LW +: LW] = q_dat[1][l*LW +: LW];
            if (q_op[1] == E_RD) begin
                e_dout = m_mem[q_addr[1]];
                e_en   = !q_dum[1];
            end else begin
                e_en = 0;
            end
            q_op[1] = q_op[0]; q_addr[1] = q_addr[0]; q_be[1] = q_be[0];
            q_dum[1] = q_dum[0]; q_dat[1] = q_dat[0];
            q_op[0] = eop; q_addr[0] = ea; q_be[0] = (eop == E_WR) ? ebe : '0;
            q_dum[0] = edum; q_dat[0] = edat;
        end
        @(negedge clk);
        if (e_en) check(tag, dout_en === 1'b1 && dout === e_dout, "dout", dout, e_dout);
        else      check(tag, dout_en === 1'b0, "dout_en", DW'(dout_en), '0);
    endtask

    task automatic rd(int a, bit oen);
        cyc(1, 0, 1, '1, oen, a, 0, E_RD, a, '0, oen, '0);
    endtask
    task automatic wr(int a, logic [NL-1:0] bwn, logic [DW-1:0] d);
        cyc(1, 0, 0, bwn, 0, a, 0, E_WR, a, ~bwn, 0, d);
    endtask
    task automatic desel();
        cyc(0, 0, 1, '1, 0, 0, 0, E_IDLE, 0, '0, 0, '0);
    endtask
    task automatic cont(bit wn, logic [NL-1:0] bwn, int eop, int ea, bit edum, logic [DW-1:0] d);
        cyc(1, 1, wn, bwn, 0, 0, 0, eop, ea, ~bwn, edum, d);
    endtask
    task automatic hold_cyc(int a, logic [DW-1:0] d);
        cyc(1, 0, 0, '0, 0, a, 1, E_WR, a, '1, 0, d);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog run did not complete");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 2; i++) begin
            q_op[i] = E_IDLE; q_addr[i] = 0; q_be[i] = '0; q_dum[i] = 0; q_dat[i] = '0;
        end
        repeat (3) @(negedge clk);
        tag = "R12";
        check(tag, dout_en === 1'b0, "dout_en in reset", DW'(dout_en), '0);
        rst_n = 1'b1;
        desel(); desel();

        // R11: fill back-to-back, read back-to-back, then alternate
        tag = "R11";
        for (int a = 0; a < (1 << AW); a++) wr(a, 2'b00, fdat(a));
        for (int a = 0; a < (1 << AW); a++) rd(a, 0);
        for (int a = 0; a < (1 << AW); a++) begin
            wr(a, 2'b00, fdat(a + 300));
            rd((a + 7) % (1 << AW), 0);
        end
        desel(); desel();

        // R1 / R2 with wrong direction pins on continues (R4)
        for (int ilv = 0; ilv < 2; ilv++) begin
            for (int s = 0; s < 4; s++) begin
                int up;
                up = ((ilv * 4 + s) << 2);
                tag = ilv ? "R1/R4" : "R2/R4";
                burst_ilv = ilv[0];
                wr(up | s, 2'b00, fdat(1000 + ilv * 16 + s * 4));
                for (int i = 1; i < 4; i++)
                    cont(1, 2'b00, E_WR, up | blow(ilv[0], s, i), 0, fdat(1000 + ilv * 16 + s * 4 + i));
                rd(up | s, 0);
                for (int i = 1; i < 4; i++)
                    cont(0, 2'b00, E_RD, up | blow(ilv[0], s, i), 0, '0);
                desel(); desel();
                burst_ilv = !ilv[0];
                for (int i = 0; i < 4; i++) rd(up | i, 0);
                desel(); desel();
            end
        end

        // R3: wrap after four continues, both orders
        tag = "R3";
        for (int ilv = 0; ilv < 2; ilv++) begin
            int b;
            b = ilv ? 13 : 22;
            burst_ilv = ilv[0];
            wr(b, 2'b00, fdat(2000 + ilv));
            for (int i = 1; i < 5; i++)
                cont(1, 2'b00, E_WR, (b & ~3) | blow(ilv[0], b & 3, i), 0, fdat(2010 + ilv * 8 + i));
            desel(); desel();
            for (int i = 0; i < 4; i++) rd((b & ~3) | i, 0);
            desel(); desel();
        end

        // R7: lane masks
        tag = "R7";
        burst_ilv = 1'b0;
        for (int a = 8; a < 12; a++) begin
            wr(a, 2'b10, fdat(3000 + a));
            wr(a + 4, 2'b01, fdat(3100 + a));
        end
        desel(); desel();
        for (int a = 8; a < 16; a++) rd(a, 0);
        desel(); desel();

        // R6: write abort and its continues
        tag = "R6";
        wr(4, 2'b11, fdat(4000));
        cont(0, 2'b11, E_WR, 5, 0, fdat(4001));
        cont(0, 2'b11, E_WR, 6, 0, fdat(4002));
        desel(); desel();
        for (int a = 4; a < 8; a++) rd(a, 0);
        desel(); desel();

        // R5: deselect then continue with write pins
        tag = "R5";
        wr(16, 2'b00, fdat(5000));
        desel();
        cont(0, 2'b00, E_IDLE, 17, 0, fdat(5001));
        cont(0, 2'b00, E_IDLE, 18, 0, fdat(5002));
        rd(17, 0);
        desel();
        for (int a = 16; a < 20; a++) rd(a, 0);
        desel(); desel();

        // R10: dummy read burst with oe_n low on continues
        tag = "R10";
        rd(20, 0);
        rd(21, 1);
        cont(1, 2'b11, E_RD, 22, 1, '0);
        cont(1, 2'b11, E_RD, 23, 1, '0);
        rd(22, 0);
        desel(); desel(); desel();

        // R9: writes between reads with oe_n low
        tag = "R9";
        rd(1, 0); wr(2, 2'b00, fdat(6000)); rd(2, 0); wr(3, 2'b00, fdat(6001));
        wr(1, 2'b00, fdat(6002)); rd(3, 0); rd(1, 0);
        desel(); desel(); desel();

        // R8: wait states during reads and during writes
        tag = "R8";
        rd(24, 0); rd(25, 0); hold_cyc(30, fdat(7000)); rd(26, 0);
        hold_cyc(30, fdat(7001)); hold_cyc(31, fdat(7002)); rd(27, 0);
        desel(); desel();
        wr(24, 2'b00, fdat(7100)); wr(25, 2'b00, fdat(7101));
        hold_cyc(30, fdat(7102)); hold_cyc(31, fdat(7103));
        desel(); hold_cyc(30, fdat(7104)); desel();
        for (int a = 24; a < 32; a++) rd(a, 0);
        desel(); desel();

        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule